// File: doc/BRIEF.md
# Multi-Line Transmit Scanner

This block sits between software and the transmit serializers of a four-line serial multiplexer. The lines share one holding register. A scanner visits the lines that software has enabled and whose serializer is idle, and it picks one of them. It then reports that line through a status word that carries a ready flag and the line number. Software answers with exactly one data write. The scanner hands that character to the chosen line's serializer as a one-cycle load strobe, and then moves on.

Software sees three word registers on a simple write/read bus. The first is a control and status word: it holds the clear, scan-enable and interrupt-enable controls, and it reads back the ready flag and the granted line. The second is a per-line enable mask. The third is a write-only transmit data register.

Lines are visited in round-robin order, starting after the last line that was granted or abandoned. If software clears the enable bit of the reported line, the scanner gives up that grant and searches again. Writing the clear control starts a timed reset, and the clear bit reads back as 1 until that reset has finished.

Top module: `mux_tx_scanner`

## Requirements
- R1: After the reset input, the control/status word (address 0) and the enable mask (address 1) read 0, `irq` is 0 and `tx_load` is 0.
- R2: The enable mask register at address 1 holds one bit per line, with bit i belonging to line i. It reads back what was written in bits [3:0], and the other bits read 0.
- R3: Control/status word layout: bit 4 clear, bit 5 scan enable, bit 6 transmit interrupt enable, bits [9:8] granted line number, bit 15 ready. Suppose scan enable is set and a line is eligible. One clock edge after the write that made the line eligible, bit 15 reads 1 and bits [9:8] hold that line's number.
- R4: A line is eligible only when its mask bit is 1 and its `line_busy` input is 0. A busy or masked line is never reported, and when no line is eligible the ready flag stays 0.
- R5: The search starts at the line after the last line that was granted or abandoned, and wraps from line 3 to line 0. After reset the search starts at line 0.
- R6: A write to the data register (address 2) while ready is 1 produces a load. In the cycle after the write edge, `tx_load` is one-hot on the reported line and `tx_char` holds the written bits [7:0]. This pulse lasts one cycle. The ready flag reads 0 in that cycle, and it can be 1 again one cycle later.
- R7: Clearing the mask bit of the reported line withdraws its grant. Within three cycles, the next eligible line in round-robin order after the abandoned one is reported, and the abandoned line receives no load.
- R8: `irq` is 1 exactly when the ready flag and the interrupt enable bit (bit 6) are both 1.
- R9: With scan enable at 0, no line is reported. Clearing scan enable while a line is reported drops the ready flag one edge after the write.
- R10: Writing 1 to bit 4 of address 0 starts a clear that lasts CLR_CYCLES cycles (default 8). During the clear, bit 4 reads 1 and bus writes are ignored. After the clear, bit 4 reads 0 and the mask and control fields read 0.
- R11: A data write made while the ready flag is 0 produces no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 control/status, 1 mask, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| line_busy | input | 4 | Per-line serializer busy |
| tx_load | output | 4 | One-hot load strobe to the line serializers |
| tx_char | output | 8 | Character presented with `tx_load` |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench walks the round-robin order through a full wrap. A scanner that restarted at line 0 each time, or that skipped the line after the last grant, would report the wrong line number.

It issues two data writes back to back, so the second one falls in the cycle when ready is low. A design that kept its grant through the write would load the same line twice.

It clears the enable bit of the reported line and of several other lines. A design that kept the grant, or searched from the wrong origin, would report a withdrawn line or the wrong successor.

It counts the clear window edge by edge and tries a mask write inside it. A window that was one cycle short, or that let the write land, would show up in the clear bit or in the mask read back.

// File: rtl/txscan_pkg.sv
`timescale 1ns/1ps
package txscan_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ADDR_CSR  = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int CSR_CLR_BIT  = 4;
    localparam int CSR_SCAN_BIT = 5;
    localparam int CSR_TIE_BIT  = 6;
    localparam int CSR_LINE_LSB = 8;
    localparam int CSR_RDY_BIT  = 15;

    typedef struct packed {
        logic scan_en;
        logic tx_ie;
    } ctrl_t;

endpackage

// File: rtl/txscan_regs.sv
`timescale 1ns/1ps
module txscan_regs
    import txscan_pkg::*;
#(
    parameter int NLINES     = 4,
    parameter int CLR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [NLINES-1:0] mask_q,
    output ctrl_t             ctrl_q,
    output logic              clearing,
    output logic              data_wr
);
    localparam int CNT_W = $clog2(CLR_CYCLES + 1);

    logic [CNT_W-1:0] clr_cnt;
    reg_addr_e        addr;

    assign addr     = reg_addr_e'(bus_addr);
    assign clearing = (clr_cnt != '0);
    assign data_wr  = bus_wr && (addr == ADDR_DATA) && !clearing;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            ctrl_q  <= '0;
            clr_cnt <= '0;
        end else if (clearing) begin
            clr_cnt <= clr_cnt - 1'b1;
            mask_q  <= '0;
            ctrl_q  <= '0;
        end else if (bus_wr && addr == ADDR_CSR) begin
            if (bus_wdata[CSR_CLR_BIT]) begin
                clr_cnt <= CNT_W'(CLR_CYCLES);
                mask_q  <= '0;
                ctrl_q  <= '0;
            end else begin
                ctrl_q.scan_en <= bus_wdata[CSR_SCAN_BIT];
                ctrl_q.tx_ie   <= bus_wdata[CSR_TIE_BIT];
            end
        end else if (bus_wr && addr == ADDR_MASK) begin
            mask_q <= bus_wdata[NLINES-1:0];
        end
    end

    // R10: once the clear window closes, every control field is back at zero
    a_r10_clear_leaves_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(clearing) |-> (mask_q == '0) && !ctrl_q.scan_en && !ctrl_q.tx_ie);

    // R10: a write landing inside the window does not reach the mask
    a_r10_mask_frozen: assert property (@(posedge clk) disable iff (rst)
        clearing |=> (mask_q == '0));

endmodule

// File: rtl/txscan_pick.sv
`timescale 1ns/1ps
module txscan_pick #(
    parameter int NLINES = 4,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] elig,
    input  logic [LW-1:0]     last,
    output logic              found,
    output logic [LW-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= NLINES; off++) begin
            int idx;
            idx = (int'(last) + off) % NLINES;
            if (!found && elig[idx[LW-1:0]]) begin
                found = 1'b1;
                pick  = idx[LW-1:0];
            end
        end
    end
endmodule

// File: rtl/txscan_grant.sv
`timescale 1ns/1ps
module txscan_grant #(
    parameter int NLINES = 4,
    parameter int DATA_W = 8,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] busy,
    input  logic              scan_en,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output logic [LW-1:0]     line,
    output logic [NLINES-1:0] tx_load,
    output logic [DATA_W-1:0] tx_char
);
    logic              grant_q;
    logic [LW-1:0]     line_q;
    logic [LW-1:0]     last_q;
    logic [NLINES-1:0] elig;
    logic [NLINES-1:0] line_oh;
    logic              found;
    logic [LW-1:0]     pick;
    logic              accept;
    logic              drop;

    assign elig    = mask & ~busy;
    assign line_oh = NLINES'(1) << line_q;
    assign accept  = grant_q && data_wr;
    assign drop    = grant_q && (!scan_en || !mask[line_q]);

    txscan_pick #(.NLINES(NLINES), .LW(LW)) u_pick (
        .elig  (elig),
        .last  (last_q),
        .found (found),
        .pick  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            line_q  <= '0;
            last_q  <= LW'(NLINES - 1);
            tx_char <= '0;
        end else if (accept) begin
            grant_q <= 1'b0;
            last_q  <= line_q;
            tx_char <= data;
        end else if (drop) begin
            grant_q <= 1'b0;
            last_q  <= line_q;
        end else if (!grant_q && scan_en && found) begin
            grant_q <= 1'b1;
            line_q  <= pick;
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_load
        always_ff @(posedge clk) begin
            if (rst) tx_load[i] <= 1'b0;
            else     tx_load[i] <= accept && line_oh[i];
        end
    end

    assign ready = grant_q;
    assign line  = line_q;

    // R6: a load strobe reaches at most one serializer
    a_r6_load_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_load));

    // R6: a load only follows a cycle in which a grant was held
    a_r6_load_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (tx_load != '0) |-> $past(grant_q));

    // R6: the grant is released by the accepted write
    a_r6_write_releases: assert property (@(posedge clk) disable iff (rst)
        accept |=> !grant_q);

    // R4: a new grant goes only to a line that was eligible when chosen
    a_r4_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        (grant_q && !$past(grant_q)) |-> |($past(elig) & line_oh));

    // R3: the reported line does not change while the grant is held
    a_r3_line_stable: assert property (@(posedge clk) disable iff (rst)
        (grant_q && $past(grant_q)) |-> $stable(line_q));

    // R7: a withdrawn enable ends the grant
    a_r7_abandon: assert property (@(posedge clk) disable iff (rst)
        (grant_q && !mask[line_q] && !data_wr) |=> !grant_q);

    // R9: no grant survives or starts while scanning is off
    a_r9_scan_off: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> !grant_q);

endmodule

// File: rtl/mux_tx_scanner.sv
`timescale 1ns/1ps
module mux_tx_scanner
    import txscan_pkg::*;
#(
    parameter int NLINES     = 4,
    parameter int DATA_W     = 8,
    parameter int CLR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NLINES-1:0] line_busy,
    output logic [NLINES-1:0] tx_load,
    output logic [DATA_W-1:0] tx_char,
    output logic              irq
);
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic [NLINES-1:0] mask_q;
    ctrl_t             ctrl_q;
    logic              clearing;
    logic              data_wr;
    logic              ready;
    logic [LW-1:0]     line;
    logic              scan_rst;

    assign scan_rst = rst | clearing;

    txscan_regs #(.NLINES(NLINES), .CLR_CYCLES(CLR_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .clearing  (clearing),
        .data_wr   (data_wr)
    );

    txscan_grant #(.NLINES(NLINES), .DATA_W(DATA_W), .LW(LW)) u_grant (
        .clk     (clk),
        .rst     (scan_rst),
        .mask    (mask_q),
        .busy    (line_busy),
        .scan_en (ctrl_q.scan_en),
        .data_wr (data_wr),
        .data    (bus_wdata[DATA_W-1:0]),
        .ready   (ready),
        .line    (line),
        .tx_load (tx_load),
        .tx_char (tx_char)
    );

    assign irq = ready && ctrl_q.tx_ie;

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            ADDR_CSR: begin
                bus_rdata[CSR_RDY_BIT]            = ready;
                bus_rdata[CSR_LINE_LSB +: LW]     = line;
                bus_rdata[CSR_TIE_BIT]            = ctrl_q.tx_ie;
                bus_rdata[CSR_SCAN_BIT]           = ctrl_q.scan_en;
                bus_rdata[CSR_CLR_BIT]            = clearing;
            end
            ADDR_MASK: bus_rdata[NLINES-1:0]      = mask_q;
            default:   bus_rdata                  = '0;
        endcase
    end

    // R10: the scanner holds no grant once the clear has taken hold
    a_r10_no_grant_in_clear: assert property (@(posedge clk) disable iff (rst)
        clearing |=> !ready);

    // R8: a request is never raised without interrupt enable
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q.tx_ie);

endmodule

// File: tb/mux_tx_scanner_test.sv
`timescale 1ns/1ps
module mux_tx_scanner_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [3:0]  line_busy = 4'h0;
    logic [3:0]  tx_load;
    logic [7:0]  tx_char;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mux_tx_scanner uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_busy (line_busy),
        .tx_load   (tx_load),
        .tx_char   (tx_char),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; line_busy = 4'h0;
        cyc(2);
        rst = 1'b0;
    endtask

    // expected status word: ready, line, and control bits
    function automatic logic [15:0] stat(input bit rdy, input int ln, input bit tie, input bit scan);
        logic [15:0] v;
        v = '0;
        v[15] = rdy; v[9:8] = ln[1:0]; v[6] = tie; v[5] = scan;
        return v;
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(0, v); chk("R1 csr", v, 16'h0);
        rd(1, v); chk("R1 mask", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 tx_load", {12'b0, tx_load}, 16'h0);
    endtask

    task automatic t_mask_rw();
        logic [15:0] v;
        wr(1, 16'hFFF5);
        rd(1, v); chk("R2 mask readback", v, 16'h0005);
        wr(1, 16'h0000);
        rd(1, v); chk("R2 mask cleared", v, 16'h0000);
    endtask

    task automatic t_nogrant_write();
        wr(2, 16'h005A);
        chk("R11 load without grant", {12'b0, tx_load}, 16'h0);
    endtask

    task automatic t_ready_irq_send();
        logic [15:0] v;
        do_reset();
        wr(1, 16'h0004);
        wr(0, 16'h0020);
        cyc(1);
        rd(0, v); chk("R3 ready line2", v, stat(1, 2, 0, 1));
        chk("R8 irq off without enable", {15'b0, irq}, 16'h0);
        wr(0, 16'h0060);
        chk("R8 irq on", {15'b0, irq}, 16'h1);
        wr(0, 16'h0020);
        chk("R8 irq off again", {15'b0, irq}, 16'h0);
        wr(2, 16'h00A5);
        chk("R6 load line2", {12'b0, tx_load}, 16'h0004);
        chk("R6 char", {8'b0, tx_char}, 16'h00A5);
        rd(0, v); chk("R6 ready low after write", v, stat(0, 2, 0, 1));
        cyc(1);
        chk("R6 single pulse", {12'b0, tx_load}, 16'h0);
        rd(0, v); chk("R6 ready again", v, stat(1, 2, 0, 1));
        wr(2, 16'h0011);
        chk("R6 first of pair loads", {12'b0, tx_load}, 16'h0004);
        wr(2, 16'h0022);
        chk("R11 second of pair ignored", {12'b0, tx_load}, 16'h0);
        chk("R11 char kept", {8'b0, tx_char}, 16'h0011);
    endtask

    task automatic t_round_robin();
        logic [15:0] v;
        do_reset();
        wr(1, 16'h000F);
        wr(0, 16'h0020);
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            rd(0, v); chk($sformatf("R5 rr step %0d", k), v, stat(1, k % 4, 0, 1));
            wr(2, 16'(8'h30 + k));
            chk($sformatf("R5 rr load %0d", k), {12'b0, tx_load}, 16'(1 << (k % 4)));
        end
    endtask

    task automatic t_busy();
        logic [15:0] v;
        do_reset();
        line_busy = 4'b0011;
        wr(1, 16'h000F);
        wr(0, 16'h0020);
        cyc(1);
        rd(0, v); chk("R4 skip busy 0,1", v, stat(1, 2, 0, 1));
        wr(2, 16'h0001);
        cyc(1);
        rd(0, v); chk("R4 next line3", v, stat(1, 3, 0, 1));
        wr(2, 16'h0002);
        cyc(1);
        rd(0, v); chk("R4 wrap past busy", v, stat(1, 2, 0, 1));
        line_busy = 4'b1111;
        wr(2, 16'h0003);
        cyc(2);
        rd(0, v); chk("R4 all busy", v[15:15], 1'b0);
        line_busy = 4'b0000;
    endtask

    task automatic t_abandon();
        logic [15:0] v;
        do_reset();
        wr(1, 16'h000F);
        wr(0, 16'h0020);
        cyc(1);
        rd(0, v); chk("R7 start line0", v, stat(1, 0, 0, 1));
        wr(1, 16'h000E);
        chk("R7 no load on abandon", {12'b0, tx_load}, 16'h0);
        cyc(2);
        rd(0, v); chk("R7 moves to line1", v, stat(1, 1, 0, 1));
        wr(1, 16'h0009);
        cyc(2);
        rd(0, v); chk("R7 successor line3", v, stat(1, 3, 0, 1));
    endtask

    task automatic t_scan_off();
        logic [15:0] v;
        wr(0, 16'h0040);
        cyc(1);
        rd(0, v); chk("R9 ready drops", v, stat(0, 3, 1, 0));
        chk("R9 irq low", {15'b0, irq}, 16'h0);
        cyc(3);
        rd(0, v); chk("R9 stays idle", v[15:15], 1'b0);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(0, 16'h0020);
        cyc(1);
        wr(0, 16'h0010);
        rd(0, v); chk("R10 clear reads 1", v[4:4], 1'b1);
        wr(1, 16'h000F);
        cyc(6);
        rd(0, v); chk("R10 clear still 1", v, 16'h0010);
        cyc(1);
        rd(0, v); chk("R10 clear done", v, 16'h0000);
        rd(1, v); chk("R10 mask write ignored", v, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_mask_rw();
        t_nogrant_write();
        t_ready_irq_send();
        t_round_robin();
        t_busy();
        t_abandon();
        t_scan_off();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule